// File: doc/BRIEF.md
# Programmable Timed-Transition Delay Unit

This block times one transition of a safe, token-based controller. The surrounding net supplies five condition inputs: the marking of the input places, the marking of the output places and the external firing condition. When all five are true at once, the unit marks the token as held and starts a delay. When the delay has run out, it pulls an active-low output to 0. The net uses that output to perform the firing itself, which moves the token. Place storage and input conditioning are outside this block.

The delay is a reference period times a multiplier. A restartable binary prescaler produces the reference period. A 4-bit selector chooses one of sixteen power-of-two taps, 2^(BASE_SHIFT+sel) clock cycles each. With the default BASE_SHIFT of 17 and a 50 MHz clock, code 0 gives about 2.621 ms and code 15 gives about 85.9 s. An 8-bit multiplier then counts whole reference periods. For example, selector 6 with multiplier 9 gives about 1.5 s, and the longest setting reaches several hours.

Top module: `tdu_timed_transition`

## Requirements
- R1: While reset is low, and after reset until arming, `fire_n` is 1 and `token_held` is 0.
- R2: The unit arms only in a cycle where every bit of `cond_in` is 1. If any subset of the bits is 1, it stays idle: `token_held` stays 0 and `fire_n` stays 1.
- R3: The reference period is 2^(BASE_SHIFT + `period_sel`) clock cycles. `period_sel` is read as an unsigned code from 0 to 15.
- R4: Count the first rising edge that samples all conditions true as edge 1. `fire_n` falls after edge P*M+1, where P is the reference period and M is the effective multiplier.
- R5: A `mult_val` of 0 is treated as a multiplier of 1. Values 1 to 255 are used as given.
- R6: `period_sel` and `mult_val` are captured on the arming edge. Changes while timing has no effect on the delay.
- R7: If any condition bit is 0 before expiry, `token_held` is 0 and `fire_n` is 1 after the next edge. A later arming restarts the full delay. A drop in the same cycle as expiry wins.
- R8: Once `fire_n` is 0, it stays 0 for as long as all conditions remain 1, and `token_held` stays 1.
- R9: After expiry, the first edge that samples any condition bit at 0 returns `fire_n` to 1 and `token_held` to 0. The unit can then arm again.
- R10: `token_held` is 1 from the arming edge until release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (50 MHz in the target system) |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_in | input | 5 | Place markings and firing condition, all required true |
| period_sel | input | 4 | Reference period tap code |
| mult_val | input | 8 | Number of reference periods (0 acts as 1) |
| fire_n | output | 1 | Active-low delay-expired indication |
| token_held | output | 1 | Token reserved by this timed transition |

## Verification
The hardest case to reach from the ports is a condition drop partway through a delay, followed by re-arming. To catch any leftover prescaler or multiplier count, the second arming must take exactly the full delay. The bench runs a shortened prescaler base. It drops one condition bit part of the way through a delay, checks the release in the next cycle, then re-arms with the same settings and compares the measured latency against the scoreboard. A separate run changes the selector and multiplier to large values in mid-delay, and its latency must still match the values captured at arming.

// File: rtl/tdu_pkg.sv
// Package: shared types and helpers for the timed-transition delay unit.
// Assumes: a single-token (safe) transition; one unit per timed transition.
package tdu_pkg;

    // Controller states: idle, counting the delay, delay expired
    typedef enum logic [1:0] {
        TDU_IDLE    = 2'd0,
        TDU_TIMING  = 2'd1,
        TDU_EXPIRED = 2'd2
    } tdu_state_e;

    // Effective multiplier: a zero code behaves as one period
    function automatic logic [7:0] tdu_eff_mult(input logic [7:0] raw);
        return (raw == 8'd0) ? 8'd1 : raw;
    endfunction

endpackage

// File: rtl/tdu_prescaler.sv
// Module: tdu_prescaler
// Restartable binary divider. While run is high, it counts clock cycles and
// pulses tick on the last cycle of each reference period, whose length
// 2^(BASE_SHIFT+sel) is chosen by sel.
// Assumes: BASE_SHIFT >= 1; sel is held stable by the caller while run is high.
module tdu_prescaler #(
    parameter int BASE_SHIFT = 17,
    parameter int SEL_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NUM_TAPS = 1 << SEL_W;
    localparam int PSC_W    = BASE_SHIFT + NUM_TAPS - 1;

    logic [PSC_W-1:0]    psc_cnt;
    logic [NUM_TAPS-1:0] tap_end;

    // One terminal-count detector per tap. The counter restarts at zero on
    // every tick, so the bits above the selected tap stay zero.
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_end[i] = &psc_cnt[BASE_SHIFT+i-1:0];
    end

    // Tick pulse when the selected tap reaches its final count
    assign tick = run && tap_end[sel];

    // Count cycles of the current period; clear when idle or at period end
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            psc_cnt <= '0;
        end else begin
            psc_cnt <= psc_cnt + PSC_W'(1);
        end
    end

endmodule

// File: rtl/tdu_mult_counter.sv
// Module: tdu_mult_counter
// Counts reference-period ticks and flags expiry on the tick that completes
// target periods.
// Assumes: target >= 1 and stable while run is high.
module tdu_mult_counter #(
    parameter int MULT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [MULT_W-1:0] target,
    output logic              expire
);
    logic [MULT_W-1:0] per_cnt;

    // Expiry on the tick that closes the last period
    assign expire = run && tick && (per_cnt == target - MULT_W'(1));

    // Number of complete periods so far; cleared whenever not timing
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            per_cnt <= '0;
        end else if (tick) begin
            per_cnt <= per_cnt + MULT_W'(1);
        end
    end

endmodule

// File: rtl/tdu_ctrl.sv
// Module: tdu_ctrl
// Transition controller. It arms when all conditions are true, captures the
// period code and the multiplier, waits for expiry, then holds the expired
// state until a condition drops.
// Assumes: cond_all is already synchronous to clk.
module tdu_ctrl
    import tdu_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int MULT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond_all,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [MULT_W-1:0] mult_in,
    input  logic              expire,
    output logic              timing,
    output logic              expired,
    output logic [SEL_W-1:0]  sel_cap,
    output logic [MULT_W-1:0] mult_cap
);
    tdu_state_e state_q, state_d;

    // Next-state choice; a condition drop takes priority over expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TDU_IDLE:    if (cond_all) state_d = TDU_TIMING;
            TDU_TIMING:  if (!cond_all) state_d = TDU_IDLE;
                         else if (expire) state_d = TDU_EXPIRED;
            TDU_EXPIRED: if (!cond_all) state_d = TDU_IDLE;
            default:     state_d = TDU_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TDU_IDLE;
        else        state_q <= state_d;
    end

    // Capture the delay settings on the arming edge only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_cap  <= '0;
            mult_cap <= MULT_W'(1);
        end else if (state_q == TDU_IDLE && cond_all) begin
            sel_cap  <= sel_in;
            mult_cap <= (mult_in == '0) ? MULT_W'(1) : mult_in;
        end
    end

    assign timing  = (state_q == TDU_TIMING);
    assign expired = (state_q == TDU_EXPIRED);

endmodule

// File: rtl/tdu_timed_transition.sv
// Module: tdu_timed_transition (top)
// Timed transition delay unit. It ANDs the condition inputs, reserves the
// token while timing, and drives fire_n low when the programmed delay of
// 2^(BASE_SHIFT+period_sel) * max(mult_val,1) cycles has elapsed.
// Assumes: condition inputs are already synchronised to clk.
module tdu_timed_transition #(
    parameter int NUM_COND   = 5,
    parameter int SEL_W      = 4,
    parameter int MULT_W     = 8,
    parameter int BASE_SHIFT = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_in,
    input  logic [SEL_W-1:0]    period_sel,
    input  logic [MULT_W-1:0]   mult_val,
    output logic                fire_n,
    output logic                token_held
);
    logic              cond_all;
    logic              timing;
    logic              expired;
    logic              tick;
    logic              expire;
    logic [SEL_W-1:0]  sel_cap;
    logic [MULT_W-1:0] mult_cap;

    // Every pre, post and firing condition must hold together
    assign cond_all = &cond_in;

    tdu_ctrl #(
        .SEL_W  (SEL_W),
        .MULT_W (MULT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_all (cond_all),
        .sel_in   (period_sel),
        .mult_in  (mult_val),
        .expire   (expire),
        .timing   (timing),
        .expired  (expired),
        .sel_cap  (sel_cap),
        .mult_cap (mult_cap)
    );

    tdu_prescaler #(
        .BASE_SHIFT (BASE_SHIFT),
        .SEL_W      (SEL_W)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timing),
        .sel   (sel_cap),
        .tick  (tick)
    );

    tdu_mult_counter #(
        .MULT_W (MULT_W)
    ) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timing),
        .tick   (tick),
        .target (mult_cap),
        .expire (expire)
    );

    assign fire_n     = !expired;
    assign token_held = timing || expired;

endmodule

// File: rtl/tdu_timed_transition_sva.sv
// Module: tdu_timed_transition_sva
// Port-level protocol checks for the timed transition unit, bound to the top.
module tdu_timed_transition_sva #(
    parameter int NUM_COND = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_COND-1:0] cond_in,
    input logic                fire_n,
    input logic                token_held
);
    // An expired indication always comes with a held token
    assert_fire_needs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_n |-> token_held);

    // A partial condition set never arms the unit
    assert_partial_no_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!token_held && !(&cond_in)) |=> !token_held);

    // Any dropped condition releases the token on the next edge
    assert_drop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cond_in) |=> (fire_n && !token_held));

    // Expired stays expired while conditions persist
    assert_expired_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_n && (&cond_in)) |=> !fire_n);

    // Full condition set arms on the next edge
    assert_arm_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!token_held && (&cond_in)) |=> token_held);

    // Expiry only follows a cycle with all conditions true
    assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fire_n) |-> $past(&cond_in));

endmodule

bind tdu_timed_transition tdu_timed_transition_sva #(
    .NUM_COND (NUM_COND)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_in    (cond_in),
    .fire_n     (fire_n),
    .token_held (token_held)
);

// File: tb/tdu_timed_transition_bench.sv
// Scoreboard bench for tdu_timed_transition, using a shortened prescaler base.
module tdu_timed_transition_bench;
    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cond_in = 5'b0;
    logic [3:0] period_sel = 4'd0;
    logic [7:0] mult_val = 8'd0;
    logic       fire_n;
    logic       token_held;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    string tag_q[$];
    int run_cnt = 0;
    logic prev_fire = 1'b1;

    always #2 clk = ~clk;

    tdu_timed_transition #(.BASE_SHIFT(BASE)) u_tdu_timed_transition (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .period_sel(period_sel),
        .mult_val(mult_val), .fire_n(fire_n), .token_held(token_held));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: counts edges with all conditions true and compares at expiry
    initial begin
        forever begin
            @(posedge clk); #1;
            if (&cond_in) run_cnt++; else run_cnt = 0;
            if (prev_fire && !fire_n) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected expiry", 1, 0);
                end else begin
                    chk(tag_q.pop_front(), run_cnt, exp_q.pop_front());
                end
            end
            prev_fire = fire_n;
        end
    end

    // Driver: arm, push the expected latency, wait, check the hold, release
    task automatic measure(input logic [3:0] sel, input logic [7:0] q,
                           input int delay, input string tag, input int chg_after);
        int lim;
        int low_ok;
        @(negedge clk);
        period_sel = sel; mult_val = q; cond_in = 5'h1f;
        exp_q.push_back(delay + 1);
        tag_q.push_back(tag);
        if (chg_after > 0) begin
            repeat (chg_after) @(negedge clk);
            period_sel = 4'd5; mult_val = 8'd200;
        end
        lim = 0;
        while (fire_n && lim < delay + 50) begin
            @(posedge clk); #1; lim++;
        end
        low_ok = 1;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            if (fire_n || !token_held) low_ok = 0;
        end
        chk("R8 expired output held low", low_ok, 1);
        @(negedge clk); cond_in = 5'h0;
        @(posedge clk); #1;
        chk("R9 release fire_n", fire_n, 1);
        chk("R9 release token_held", token_held, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int ok;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset fire_n", fire_n, 1);
        chk("R1 reset token_held", token_held, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 post-reset token_held", token_held, 0);

        // R2: partial condition sets never arm
        ok = 1;
        for (int b = 0; b < 5; b++) begin
            @(negedge clk); cond_in = 5'h1f & ~(5'h1 << b);
            repeat (10) begin
                @(posedge clk); #1;
                if (token_held || !fire_n) ok = 0;
            end
        end
        chk("R2 partial conditions ignored", ok, 1);
        @(negedge clk); cond_in = 5'h0;

        // R10: holding starts on the arming edge
        @(negedge clk); period_sel = 4'd0; mult_val = 8'd3; cond_in = 5'h1f;
        exp_q.push_back(13); tag_q.push_back("R4 sel0 q3");
        @(posedge clk); #1;
        chk("R10 token held after arm", token_held, 1);
        chk("R10 fire_n high while timing", fire_n, 1);
        repeat (20) @(posedge clk);
        @(negedge clk); cond_in = 5'h0;
        repeat (2) @(negedge clk);

        measure(4'd1, 8'd9, 72, "R3 R4 sel1 q9", 0);
        measure(4'd3, 8'd2, 64, "R3 sel3 q2", 0);
        measure(4'd0, 8'd0, 4, "R5 q0 acts as 1", 0);
        measure(4'd1, 8'd0, 8, "R5 q0 sel1", 0);
        measure(4'd0, 8'd255, 1020, "R4 sel0 q255", 0);
        measure(4'd0, 8'd4, 16, "R6 settings captured at arm", 3);

        // R7: abort mid-delay, then the full delay on re-arm
        @(negedge clk); period_sel = 4'd1; mult_val = 8'd5; cond_in = 5'h1f;
        repeat (20) @(posedge clk);
        #1;
        chk("R7 held before abort", token_held, 1);
        @(negedge clk); cond_in = 5'b10111;
        @(posedge clk); #1;
        chk("R7 abort releases token", token_held, 0);
        chk("R7 abort fire_n high", fire_n, 1);
        ok = 1;
        repeat (30) begin
            @(posedge clk); #1;
            if (!fire_n || token_held) ok = 0;
        end
        chk("R7 stays idle after abort", ok, 1);
        measure(4'd1, 8'd5, 40, "R7 full delay after abort", 0);

        repeat (5) @(posedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule